// File: doc/BRIEF.md
# Serial EEPROM Single-Word Read Controller

This block fetches one 16-bit word from a three-wire serial EEPROM with 128x16 or 256x16 word organisation. The host presents an 8-bit word address and pulses a start strobe. The controller then frames the whole transfer on the serial pins: it asserts select, sends an 11-bit read command, clocks in sixteen data bits, and deselects the device. It returns the word together with a one-cycle completion pulse.

Every serial clock phase lasts a fixed number of system clock cycles. That count comes from the `HALF_CYCLES` parameter, so the same design can drive a slow part in silicon and use a short phase in simulation. A protect-enable output sits low while a transfer is in flight and high when the block is idle. Only the read transaction is built. Programming, erase and protect-register commands are not part of this block.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, and whenever the block is idle, the pins are: select low, serial clock high, data out low, protect-enable high. `done_o` is low, and after reset `rdata_o` is zero.
- R2: A start strobe is accepted only in a cycle where the block is idle, which includes the cycle in which `done_o` is high. A strobe seen while a transfer is in progress has no effect on the pins, the result or the number of completions.
- R3: The address is captured in the cycle the strobe is accepted. Later changes to `addr_i` do not alter the transfer in progress.
- R4: A transfer opens with one phase in which select, clock, data out and protect-enable are all low. Next comes one phase with select high and clock high.
- R5: The command is 11 bits, sent most significant first: 1, 1, 0, then address bits 7 down to 0. Each bit is one phase with the clock low and then one phase with the clock high, and data out holds the bit value through both phases.
- R6: Every phase of the transfer lasts exactly `HALF_CYCLES` clock cycles.
- R7: After the last command bit, the block drives data out low and runs 16 read bits. Each read bit is one phase with the clock low followed by one phase with the clock high.
- R8: `ee_din_i` is sampled at the last cycle of each high read phase, and bits are assembled most significant first into the returned word.
- R9: The transfer closes with one phase in which the clock is low and select is still high. It is followed by one phase with select low, protect-enable high and the clock low. The block then returns to the idle pin state with the clock high.
- R10: Protect-enable is low in every cycle from the first select phase through the last phase in which select is high.
- R11: `done_o` is high for exactly one cycle, the first idle cycle after the closing phase. `rdata_o` takes the new word in that same cycle and holds it until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for one read |
| addr_i | input | ADDR_W | Word address, captured when the strobe is accepted |
| rdata_o | output | DATA_W | Last word read |
| done_o | output | 1 | One-cycle completion pulse |
| ee_cs_o | output | 1 | Serial device select |
| ee_sclk_o | output | 1 | Serial clock |
| ee_dout_o | output | 1 | Serial data toward the device |
| ee_din_i | input | 1 | Serial data from the device |
| ee_prot_o | output | 1 | Protect-enable, low during a transfer |

## Verification
The case that is hardest to reach from the ports is a strobe that arrives in the very cycle a transfer completes. At that point the block is idle for a single cycle, and the new transfer must start there without any gap or any lost phase. The bench holds the strobe high straight through a completion to land exactly on that cycle. It also fires strobes with a different address in the middle of a transfer, which exercises both the ignore rule and address capture. A behavioural device model decodes the command it actually receives and returns a computed word from it, so a wrong bit order or a sample taken in the wrong phase changes the returned data.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SEL_WAIT,
    PH_SEL_ON,
    PH_CMD_LO,
    PH_CMD_HI,
    PH_RD_LO,
    PH_RD_HI,
    PH_DES_CLK,
    PH_DES_CS
  } mwr_phase_e;

  localparam int unsigned OPC_W = 3;
  localparam logic [OPC_W-1:0] RD_OPCODE = 3'b110;

endpackage

// File: rtl/mwr_phase_timer.sv
module mwr_phase_timer #(
  parameter int unsigned HALF_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run || (cnt_q == '0)) cnt_d = RELOAD;
    else                       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/mwr_sequencer.sv
module mwr_sequencer
  import mwr_pkg::*;
#(
  parameter int unsigned CMD_BITS  = 11,
  parameter int unsigned DATA_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  output mwr_phase_e phase,
  output logic       busy,
  output logic       load,
  output logic       shift_cmd,
  output logic       sample,
  output logic       finish
);

  localparam int unsigned MAXB  = (CMD_BITS > DATA_BITS) ? CMD_BITS : DATA_BITS;
  localparam int unsigned IDX_W = $clog2(MAXB);
  localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_BITS - 1);
  localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_BITS - 1);

  mwr_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    phase_d   = phase_q;
    idx_d     = idx_q;
    load      = 1'b0;
    shift_cmd = 1'b0;
    sample    = 1'b0;
    finish    = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SEL_WAIT;
          idx_d   = '0;
          load    = 1'b1;
        end
      end
      PH_SEL_WAIT: if (tick) phase_d = PH_SEL_ON;
      PH_SEL_ON:   if (tick) phase_d = PH_CMD_LO;
      PH_CMD_LO:   if (tick) phase_d = PH_CMD_HI;
      PH_CMD_HI: begin
        if (tick) begin
          shift_cmd = 1'b1;
          if (idx_q == CMD_LAST) begin
            phase_d = PH_RD_LO;
            idx_d   = '0;
          end else begin
            phase_d = PH_CMD_LO;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      PH_RD_LO:    if (tick) phase_d = PH_RD_HI;
      PH_RD_HI: begin
        if (tick) begin
          sample = 1'b1;
          if (idx_q == DATA_LAST) begin
            phase_d = PH_DES_CLK;
          end else begin
            phase_d = PH_RD_LO;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      PH_DES_CLK:  if (tick) phase_d = PH_DES_CS;
      PH_DES_CS: begin
        if (tick) begin
          finish  = 1'b1;
          phase_d = PH_IDLE;
        end
      end
      default:     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase = phase_q;
  assign busy  = (phase_q != PH_IDLE);

  // R6: a busy phase only moves on when the timer ticks
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && !tick) |=> $stable(phase_q));

  // R2: once past the first phase, the transfer never restarts
  p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_q != PH_SEL_WAIT) |=> (phase_q != PH_SEL_WAIT));

endmodule

// File: rtl/mwr_shifter.sv
module mwr_shifter
  import mwr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              shift_cmd,
  input  logic              sample,
  input  logic              din,
  input  logic              finish,
  output logic              cmd_bit,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  localparam int unsigned CMD_W = ADDR_W + OPC_W;

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              cmd_en, rx_en;

  assign cmd_en = load || shift_cmd;
  assign rx_en  = sample;

  always_comb begin
    if (load) cmd_d = {RD_OPCODE, addr};
    else      cmd_d = {cmd_q[CMD_W-2:0], 1'b0};
    rx_d = {rx_q[DATA_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (cmd_en) cmd_q   <= cmd_d;
      if (rx_en)  rx_q    <= rx_d;
      if (finish) rdata_q <= rx_q;
      done_q <= finish;
    end
  end

  assign cmd_bit = cmd_q[CMD_W-1];
  assign rdata   = rdata_q;
  assign done    = done_q;

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: the result only moves together with a completion
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mwr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned HALF_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              ee_cs_o,
  output logic              ee_sclk_o,
  output logic              ee_dout_o,
  input  logic              ee_din_i,
  output logic              ee_prot_o
);

  localparam int unsigned CMD_BITS = ADDR_W + OPC_W;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  mwr_phase_e phase;
  logic busy, tick, load, shift_cmd, sample, finish, cmd_bit;

  mwr_phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (busy),
    .tick  (tick)
  );

  mwr_sequencer #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start_i),
    .tick      (tick),
    .phase     (phase),
    .busy      (busy),
    .load      (load),
    .shift_cmd (shift_cmd),
    .sample    (sample),
    .finish    (finish)
  );

  mwr_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (load),
    .addr      (addr_i),
    .shift_cmd (shift_cmd),
    .sample    (sample),
    .din       (ee_din_i),
    .finish    (finish),
    .cmd_bit   (cmd_bit),
    .rdata     (rdata_o),
    .done      (done_o)
  );

  always_comb begin
    ee_cs_o   = 1'b1;
    ee_sclk_o = 1'b0;
    ee_dout_o = 1'b0;
    ee_prot_o = 1'b0;
    case (phase)
      PH_IDLE: begin
        ee_cs_o   = 1'b0;
        ee_sclk_o = 1'b1;
        ee_prot_o = 1'b1;
      end
      PH_SEL_WAIT: ee_cs_o = 1'b0;
      PH_SEL_ON:   ee_sclk_o = 1'b1;
      PH_CMD_LO:   ee_dout_o = cmd_bit;
      PH_CMD_HI: begin
        ee_sclk_o = 1'b1;
        ee_dout_o = cmd_bit;
      end
      PH_RD_HI:    ee_sclk_o = 1'b1;
      PH_DES_CS: begin
        ee_cs_o   = 1'b0;
        ee_prot_o = 1'b1;
      end
      default: ;
    endcase
  end

  // R10: protect-enable stays low while the device is selected
  p_prot_low_sel_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    ee_cs_o |-> !ee_prot_o);

  // R4: select rises together with the clock, with data out low
  p_cs_rise_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(ee_cs_o) |-> (ee_sclk_o && !ee_dout_o && !ee_prot_o));

  // R5: data out never changes while the clock stays high
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    ee_sclk_o |=> (!ee_sclk_o || $stable(ee_dout_o)));

  // R9: select falls only while the clock is low
  p_cs_fall_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(ee_cs_o) |-> (!ee_sclk_o && ee_prot_o));

endmodule

// File: tb/mw_eeprom_reader_bench.sv
module mw_eeprom_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam logic [3:0] PINS_IDLE = 4'b0101; // {cs, sclk, dout, prot}

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  addr = '0;
  logic        din = 1'b1;
  logic [15:0] rdata;
  logic        done, cs, sclk, dout, prot;

  int n_cmp = 0;
  int n_bad = 0;
  int n_done = 0;
  bit cmp_en = 1'b0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_reader #(.ADDR_W(8), .DATA_W(16), .HALF_CYCLES(HALF)) u_mw_eeprom_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .rdata_o(rdata), .done_o(done), .ee_cs_o(cs), .ee_sclk_o(sclk),
    .ee_dout_o(dout), .ee_din_i(din), .ee_prot_o(prot)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    logic [15:0] w;
    w = (16'(a) * 16'h1F3B) ^ 16'hC35A;
    return w + {a, ~a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int          m_rel = 0;
  bit          m_busy = 1'b0;
  logic [3:0]  m_pins = PINS_IDLE;
  string       m_tag = "R1";
  logic        m_done = 1'b0;
  logic [15:0] m_rdata = '0;
  logic [7:0]  m_addr = '0;
  logic [3:0]  q_pins[$];
  string       q_tag[$];

  task automatic push_phase(input logic [3:0] p, input string t);
    for (int k = 0; k < HALF; k++) begin
      q_pins.push_back(p);
      q_tag.push_back(t);
    end
  endtask

  task automatic build_transfer(input logic [7:0] a);
    logic [10:0] fr;
    fr = {3'b110, a};
    push_phase(4'b0000, "R4");
    push_phase(4'b1100, "R4");
    for (int i = 10; i >= 0; i--) begin
      push_phase({2'b10, fr[i], 1'b0}, "R5");
      push_phase({2'b11, fr[i], 1'b0}, "R5");
    end
    for (int i = 0; i < 16; i++) begin
      push_phase(4'b1000, "R7");
      push_phase(4'b1100, "R7");
    end
    push_phase(4'b1000, "R9");
    push_phase(4'b0001, "R9");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rel = 0; m_busy = 1'b0; m_pins = PINS_IDLE; m_tag = "R1";
      m_done = 1'b0; m_rdata = '0;
      q_pins.delete(); q_tag.delete();
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (q_pins.size() > 0) begin
          m_pins = q_pins.pop_front();
          m_tag  = q_tag.pop_front();
        end else begin
          m_busy = 1'b0; m_pins = PINS_IDLE; m_tag = "R1";
          m_done = 1'b1; m_rdata = mem_word(m_addr);
        end
      end else if (start) begin
        m_busy = 1'b1;
        m_addr = addr;
        build_transfer(addr);
        m_pins = q_pins.pop_front();
        m_tag  = q_tag.pop_front();
      end
    end
  end

  // ---------------- device model and per-cycle compare ----------------
  int          edges = 0;
  logic [10:0] rx_cmd = '0;
  logic [15:0] dev_word = '0;
  logic        prev_sk = 1'b1;
  logic        prev_cs = 1'b0;

  always @(negedge clk) begin
    if (cmp_en) begin
      chk({cs, sclk, dout, prot} === m_pins, {m_tag, " R6 R10 pins"}, {28'd0, cs, sclk, dout, prot}, {28'd0, m_pins});
      chk(done === m_done, "R11 done", {31'd0, done}, {31'd0, m_done});
      chk(rdata === m_rdata, "R8 rdata", {16'd0, rdata}, {16'd0, m_rdata});
      if (done) n_done++;
    end
    if (!cs) begin
      edges = 0;
      din = 1'b1;
    end else if (sclk && !prev_sk && prev_cs) begin
      edges++;
      if (edges <= 11) begin
        rx_cmd = {rx_cmd[9:0], dout};
        if (edges == 11)
          dev_word = (rx_cmd[10:8] == 3'b110) ? mem_word(rx_cmd[7:0]) : 16'hDEAD;
      end else if (edges <= 27) begin
        din = dev_word[27 - edges];
      end
    end
    prev_sk = sclk;
    prev_cs = cs;
  end

  // ---------------- stimulus ----------------
  task automatic start_read(input logic [7:0] a);
    @(negedge clk);
    start = 1'b1;
    addr  = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic read_and_check(input logic [7:0] a);
    start_read(a);
    wait_done();
    chk(rdata === mem_word(a), "R8 R5 word", {16'd0, rdata}, {16'd0, mem_word(a)});
    @(negedge clk);
    chk(done === 1'b0, "R11 pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog expired: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int d0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    cmp_en = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle pin state after reset
    chk({cs, sclk, dout, prot} === PINS_IDLE, "R1 reset pins", {28'd0, cs, sclk, dout, prot}, {28'd0, PINS_IDLE});
    chk(rdata === 16'd0 && done === 1'b0, "R1 reset result", {15'd0, done, rdata}, 32'd0);

    // R5 R8: several address patterns
    read_and_check(8'h00);
    read_and_check(8'hFF);
    read_and_check(8'hA5);
    read_and_check(8'h5A);
    read_and_check(8'h80);
    read_and_check(8'h7F);

    // R3: address changes after acceptance
    start_read(8'h33);
    addr = 8'hCC;
    repeat (20) @(negedge clk);
    addr = 8'h01;
    wait_done();
    chk(rdata === mem_word(8'h33), "R3 captured address", {16'd0, rdata}, {16'd0, mem_word(8'h33)});

    // R2: strobes during a busy transfer are ignored
    repeat (3) @(negedge clk);
    d0 = n_done;
    start_read(8'h11);
    repeat (10) @(negedge clk);
    start_read(8'h22);
    repeat (50) @(negedge clk);
    start_read(8'h99);
    wait_done();
    chk(rdata === mem_word(8'h11), "R2 busy strobe ignored", {16'd0, rdata}, {16'd0, mem_word(8'h11)});
    repeat (HALF * 70) @(negedge clk);
    chk(n_done - d0 === 1, "R2 completion count", n_done - d0, 32'd1);
    chk(cs === 1'b0 && prot === 1'b1, "R2 stays idle", {30'd0, cs, prot}, 32'd1);

    // R11: result holds while idle
    chk(rdata === mem_word(8'h11), "R11 result held", {16'd0, rdata}, {16'd0, mem_word(8'h11)});

    // R2: strobe held through completion restarts in the done cycle
    @(negedge clk);
    start = 1'b1;
    addr  = 8'h44;
    wait_done();
    addr = 8'h45;
    chk(rdata === mem_word(8'h44), "R2 first of back-to-back", {16'd0, rdata}, {16'd0, mem_word(8'h44)});
    @(negedge clk);
    start = 1'b0;
    chk({cs, sclk, prot} === 3'b000, "R2 R4 immediate restart", {29'd0, cs, sclk, prot}, 32'd0);
    wait_done();
    chk(rdata === mem_word(8'h45), "R2 second of back-to-back", {16'd0, rdata}, {16'd0, mem_word(8'h45)});

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule